// File: doc/BRIEF.md
# RTC Alarm Match Comparator

This block sits beside a real-time calendar counter. Once per second it checks the running calendar against a set of programmable alarm values and raises an alarm interrupt when a check finds a hit. The calendar counter supplies the current time as BCD fields: seconds, minutes, hours, day of month, month (1 to 12) and a three-digit year. It also supplies a one-cycle strobe in the same cycle as each freshly incremented time. The block keeps no time of its own.

Software programs one alarm register per field and a control register. The control register holds an enable for each field and a global enable. Any single enabled field that equals its alarm value triggers the alarm: the enabled fields are ORed, not ANDed. The global enable decides whether a check takes place at all. A hit sets a sticky pending bit, which drives the interrupt line. Software clears the bit by writing a 1 to its position in the status register. A small write/read port reaches the registers, selected by a 3-bit code.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, alarm_pending and alarm_irq are 0 and every register (select codes 0 to 7) reads 0.
- R2: Select codes 1 to 6 address the seconds, minutes, hours, day, month and year alarm registers. A write keeps only the low 7 bits for seconds and minutes, 6 bits for hours and day, 5 bits for month and 12 bits for year, and the register reads back the masked value.
- R3: Select code 0 is the control register. Bits 0 to 5 enable the seconds, minutes, hours, day, month and year comparisons, and bit 6 is the global enable. It reads back as the written value masked to 7 bits.
- R4: A check in which at least one enabled field equals its alarm register sets the pending bit, even when other enabled fields differ.
- R5: A field whose enable bit is 0 never causes the alarm, even when it matches.
- R6: While control bit 6 is 0, no check is made and the pending bit is not set, whatever the fields hold.
- R7: A check is made only in a cycle where sec_tick is 1, using the calendar values present in that cycle. The pending bit rises at the next clock edge.
- R8: alarm_irq equals alarm_pending. Select code 7 reads back the status, with the pending bit at bit 1 and all other bits 0.
- R9: A write to select code 7 with bit 1 set clears the pending bit. A write to code 7 with bit 1 clear leaves it unchanged.
- R10: Once set, the pending bit stays set through later checks, hits or misses, until software clears it. If a hit and a clear write fall in the same cycle, the bit stays set.
- R11: The month is compared as a BCD value from 1 to 12, and the year as a full 12-bit, three-digit BCD value that includes the hundreds digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe: the calendar fields were just updated |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD 1 to 12 |
| cur_year | input | 12 | Current year, three BCD digits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 12 | Write data |
| rd_sel | input | 3 | Register select for readback |
| rd_data | output | 12 | Readback data (combinational) |
| alarm_pending | output | 1 | Sticky alarm pending bit |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The bench enables each field alone and makes only that field match. A design with the enable bits in the wrong order, or the fields cross-wired, fires on the wrong field or on none. It then checks a lone match with every field enabled: a design that ANDs the enables would stay silent. It also checks a match with the global enable clear, and a match on a disabled field; a design that ignores either would fire. Further cases cover a hit with no strobe, a status write carrying only bit 0, and a clear in the same cycle as a new hit. A design that dropped the strobe qualifier, decoded the wrong clear bit or let the clear take priority would change the pending bit where it must hold. Writes of all ones expose any wrong register mask in the readback.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

  localparam int NUM_FIELDS    = 6;
  localparam int CMP_W         = 12;
  localparam int SEL_W         = 3;
  localparam int CTRL_GLB_BIT  = NUM_FIELDS;
  localparam int STAT_ALM_BIT  = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_SEC  = 3'd1,
    SEL_MIN  = 3'd2,
    SEL_HOUR = 3'd3,
    SEL_DAY  = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_STAT = 3'd7
  } reg_sel_e;

  // Storage mask for alarm field idx (0 = seconds ... 5 = year).
  function automatic logic [CMP_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    return 12'h07f;
      2, 3:    return 12'h03f;
      4:       return 12'h01f;
      default: return 12'hfff;
    endcase
  endfunction

  // Field hit: enabled and equal.
  function automatic logic field_equal(input logic en,
                                       input logic [CMP_W-1:0] cur,
                                       input logic [CMP_W-1:0] alm);
    return en && (cur == alm);
  endfunction

endpackage

// File: rtl/rtc_alm_regs.sv
module rtc_alm_regs
  import rtc_alm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int DW = CMP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [DW-1:0]          wr_data,
  input  logic [SEL_W-1:0]       rd_sel,
  input  logic                   pending,
  output logic [NF-1:0][DW-1:0]  alm_val,
  output logic [NF:0]            ctrl,
  output logic                   clr_req,
  output logic [DW-1:0]          rd_data
);

  localparam int CTRL_W = NF + 1;

  logic ctrl_wr;
  logic stat_wr;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign stat_wr = wr_en && (wr_sel == SEL_STAT);
  assign clr_req = stat_wr && wr_data[STAT_ALM_BIT];

  for (genvar gi = 0; gi < NF; gi++) begin : g_alm
    logic [DW-1:0] alm_q;
    logic          fld_wr;
    assign fld_wr = wr_en && (wr_sel == SEL_W'(gi + 1));
    always_ff @(posedge clk) begin
      if (!rst_n)      alm_q <= '0;
      else if (fld_wr) alm_q <= wr_data & DW'(field_mask(gi));
    end
    assign alm_val[gi] = alm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= wr_data[CTRL_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: rd_data = DW'(ctrl);
      SEL_STAT: rd_data[STAT_ALM_BIT] = pending;
      default:  rd_data = alm_val[rd_sel - SEL_W'(1)];
    endcase
  end

  // R2
  sec_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SEC) |=> (alm_val[0] == ($past(wr_data) & DW'(12'h07f))));

  // R2
  year_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_YEAR) |=> (alm_val[NF-1] == $past(wr_data)));

  // R3
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl == $past(wr_data[CTRL_W-1:0])));

endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp
  import rtc_alm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int DW = CMP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_tick,
  input  logic [NF:0]            ctrl,
  input  logic [NF-1:0][DW-1:0]  alm_val,
  input  logic [NF-1:0][DW-1:0]  cur_val,
  output logic [NF-1:0]          field_hit,
  output logic                   match_evt
);

  logic check_en;

  for (genvar gi = 0; gi < NF; gi++) begin : g_cmp
    assign field_hit[gi] = field_equal(ctrl[gi], cur_val[gi], alm_val[gi]);
  end

  assign check_en  = sec_tick && ctrl[NF];
  assign match_evt = check_en && (|field_hit);

  // R7
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> !match_evt);

  // R6
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[NF] |-> !match_evt);

  // R5
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_hit & ~ctrl[NF-1:0]) == '0);

endmodule

// File: rtl/rtc_alm_pend.sv
module rtc_alm_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_evt) pending <= 1'b1;
    else if (clr_req) pending <= 1'b0;
  end

  // R7
  set_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pending);

  // R9
  clr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !pending);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_req) |=> pending);

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !set_evt) |=> !pending);

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alm_pkg::*;
#(
  parameter int DW = CMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [7:0]       cur_sec,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hour,
  input  logic [7:0]       cur_day,
  input  logic [7:0]       cur_mon,
  input  logic [11:0]      cur_year,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [2:0]       rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             alarm_pending,
  output logic             alarm_irq
);

  localparam int NF = NUM_FIELDS;

  logic [NF-1:0][DW-1:0] cur_val;
  logic [NF-1:0][DW-1:0] alm_val;
  logic [NF:0]           ctrl;
  logic [NF-1:0]         field_hit;
  logic                  match_evt;
  logic                  clr_req;
  logic                  pending;

  assign cur_val[0] = DW'(cur_sec);
  assign cur_val[1] = DW'(cur_min);
  assign cur_val[2] = DW'(cur_hour);
  assign cur_val[3] = DW'(cur_day);
  assign cur_val[4] = DW'(cur_mon);
  assign cur_val[5] = DW'(cur_year);

  rtc_alm_regs #(.NF(NF), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .pending (pending),
    .alm_val (alm_val),
    .ctrl    (ctrl),
    .clr_req (clr_req),
    .rd_data (rd_data)
  );

  rtc_alm_cmp #(.NF(NF), .DW(DW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .ctrl      (ctrl),
    .alm_val   (alm_val),
    .cur_val   (cur_val),
    .field_hit (field_hit),
    .match_evt (match_evt)
  );

  rtc_alm_pend u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (match_evt),
    .clr_req (clr_req),
    .pending (pending)
  );

  assign alarm_pending = pending;
  assign alarm_irq     = pending;

  // R10
  clr_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && clr_req) |=> alarm_irq);

endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [7:0]  cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0]  cur_day = 8'h01, cur_mon = 8'h01;
  logic [11:0] cur_year = 12'h024;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [11:0] wr_data = 12'h000;
  logic [2:0]  rd_sel = 3'd0;
  logic [11:0] rd_data;
  logic        alarm_pending, alarm_irq;

  int n_chk = 0;
  int n_err = 0;

  // alarm values used throughout (index: 0 sec .. 5 year)
  logic [11:0] alm_tab [6] = '{12'h045, 12'h021, 12'h013, 12'h017, 12'h009, 12'h125};

  always #10 clk = ~clk;

  rtc_alarm_match u_rtc_alarm_match (
    .clk, .rst_n, .sec_tick, .cur_sec, .cur_min, .cur_hour, .cur_day,
    .cur_mon, .cur_year, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data,
    .alarm_pending, .alarm_irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [11:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic time_miss();
    cur_sec = 8'h00; cur_min = 8'h00; cur_hour = 8'h00;
    cur_day = 8'h01; cur_mon = 8'h01; cur_year = 12'h024;
  endtask

  task automatic time_field(input int idx, input logic [11:0] v);
    case (idx)
      0: cur_sec  = v[7:0];
      1: cur_min  = v[7:0];
      2: cur_hour = v[7:0];
      3: cur_day  = v[7:0];
      4: cur_mon  = v[7:0];
      default: cur_year = v;
    endcase
  endtask

  task automatic load_alarms();
    for (int i = 0; i < 6; i++) wr(3'(i + 1), alm_tab[i]);
  endtask

  task automatic clear_pend();
    wr(3'd7, 12'h002);
  endtask

  task automatic t_reset();
    logic [11:0] d;
    chk("R1 pending", alarm_pending, 0);
    chk("R1 irq", alarm_irq, 0);
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), d);
      chk("R1 reg", d, 0);
    end
  endtask

  task automatic t_masks();
    logic [11:0] d;
    logic [11:0] exp_tab [6] = '{12'h07f, 12'h07f, 12'h03f, 12'h03f, 12'h01f, 12'hfff};
    for (int i = 0; i < 6; i++) begin
      wr(3'(i + 1), 12'hfff);
      rd(3'(i + 1), d);
      chk("R2 mask", d, exp_tab[i]);
    end
    wr(3'd0, 12'hfff);
    rd(3'd0, d);
    chk("R3 ctrl readback", d, 12'h07f);
    wr(3'd0, 12'h000);
    load_alarms();
    rd(3'd5, d);
    chk("R2 month value", d, 12'h009);
  endtask

  task automatic t_single_fields();
    logic [11:0] d;
    for (int i = 0; i < 6; i++) begin
      time_miss();
      time_field(i, alm_tab[i]);
      wr(3'd0, 12'h040 | (12'h001 << i));
      tick();
      chk("R3 R4 field fires", alarm_irq, 1);
      rd(3'd7, d);
      chk("R8 status", d, 12'h002);
      clear_pend();
      chk("R9 cleared", alarm_pending, 0);
    end
    time_miss();
  endtask

  task automatic t_or_of_fields();
    time_miss();
    cur_mon = 8'h09;
    wr(3'd0, 12'h07f);
    tick();
    chk("R4 R11 lone month hit", alarm_pending, 1);
    clear_pend();
    time_miss();
    cur_year = 12'h125;
    tick();
    chk("R11 year hit", alarm_pending, 1);
    clear_pend();
    cur_year = 12'h025;
    tick();
    chk("R11 hundreds digit", alarm_pending, 0);
    time_miss();
  endtask

  task automatic t_disabled_field();
    time_miss();
    cur_sec = 8'h45;
    wr(3'd0, 12'h07e);
    tick();
    chk("R5 disabled field", alarm_pending, 0);
    time_miss();
  endtask

  task automatic t_global_off();
    for (int i = 0; i < 6; i++) time_field(i, alm_tab[i]);
    wr(3'd0, 12'h03f);
    tick();
    tick();
    chk("R6 global off", alarm_irq, 0);
    time_miss();
  endtask

  task automatic t_strobe();
    time_miss();
    cur_sec = 8'h45;
    wr(3'd0, 12'h041);
    repeat (4) @(negedge clk);
    chk("R7 no strobe", alarm_pending, 0);
    sec_tick = 1'b1;
    #1;
    chk("R7 before edge", alarm_pending, 0);
    @(negedge clk);
    sec_tick = 1'b0;
    chk("R7 after edge", alarm_pending, 1);
    chk("R8 irq follows", alarm_irq, alarm_pending);
  endtask

  task automatic t_clear_rules();
    // pending is 1 from t_strobe
    wr(3'd7, 12'h001);
    chk("R9 bit0 only", alarm_pending, 1);
    wr(3'd7, 12'hffd);
    chk("R9 bit1 clear", alarm_pending, 1);
    time_miss();
    tick();
    chk("R10 sticky on miss", alarm_pending, 1);
    cur_sec = 8'h45;
    tick();
    chk("R10 sticky on hit", alarm_pending, 1);
    // hit and clear in same cycle
    @(negedge clk);
    sec_tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd7; wr_data = 12'h002;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    chk("R10 set beats clear", alarm_pending, 1);
    clear_pend();
    chk("R9 clear works", alarm_irq, 0);
    time_miss();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_single_fields();
    t_or_of_fields();
    t_disabled_field();
    t_global_off();
    t_strobe();
    t_clear_rules();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule